// File: doc/BRIEF.md
# Transmit Collision Retry Controller

This block manages the transmit attempts for one frame at a time on a half-duplex medium. When the transmit datapath announces a new frame, the controller clears the frame's status and follows the attempt. If the attempt ends cleanly, the controller tells the datapath to move on. If a collision ends the attempt, the controller either waits for the backoff timer and then asks for another attempt, or it abandons the frame. It abandons the frame when the attempt budget is used up, or when a late collision happens and retrying after late collisions is switched off.

Two control inputs select the policy. `single_try_i` limits each frame to one attempt instead of `MAX_TRIES` (16) attempts. `late_retry_i` decides whether a late collision is retried like an ordinary one or ends the frame. The per-frame status reports these items: a saturating collision count, a retry-error flag, a late-collision flag and a done flag. It stays valid until the next frame starts.

Top module: `txretry_ctrl`

## Requirements
- R1: After reset, `retry_req_o`, `abort_o`, `next_o`, `stat_done_o`, `stat_err_o`, `stat_late_o` are 0 and `stat_ccount_o` is 0.
- R2: A `frame_start_i` pulse while idle clears all four status fields and begins an attempt. A `frame_start_i` pulse while a frame is in progress is ignored.
- R3: `attempt_done_i` without a collision in the same cycle produces a one-cycle `next_o` one clock later, with `abort_o`=0. It also sets `stat_done_o`=1 and leaves `stat_err_o`=0.
- R4: A retryable collision produces no `abort_o` or `next_o`. The controller then waits. `retry_req_o` pulses for one cycle, one clock after `backoff_done_i`. A `backoff_done_i` while an attempt is running is ignored.
- R5: With `single_try_i`=1, the first collision produces `abort_o` and `next_o` together one clock later, and sets `stat_err_o`=1.
- R6: With `single_try_i`=0, exactly `MAX_TRIES` attempts are made. A collision on the last attempt aborts the frame with `stat_err_o`=1, after `MAX_TRIES`-1 retry requests.
- R7: `stat_ccount_o` (4 bits) counts every collision of the frame, late ones included, and saturates at 15.
- R8: With `late_retry_i`=0, a late collision aborts the frame with `stat_late_o`=1 and `stat_err_o`=0.
- R9: With `late_retry_i`=1, a late collision is retried like an ordinary collision. `stat_late_o` becomes 1 and stays 1 until the next frame starts.
- R10: `coll_i` and `late_coll_i` are ignored while no attempt is running. While idle they change no status field and produce no pulse.
- R11: When `attempt_done_i` and a collision arrive in the same cycle, the collision takes effect and no `next_o` is produced unless the frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Pulse: datapath begins a new frame |
| attempt_done_i | input | 1 | Pulse: current attempt finished on the wire |
| coll_i | input | 1 | Pulse: collision inside the collision window |
| late_coll_i | input | 1 | Pulse: collision after the collision window |
| backoff_done_i | input | 1 | Pulse: backoff delay elapsed |
| single_try_i | input | 1 | 1 = one attempt per frame, 0 = MAX_TRIES attempts |
| late_retry_i | input | 1 | 1 = retry after late collisions, 0 = abandon |
| retry_req_o | output | 1 | Pulse: start another attempt of the same frame |
| abort_o | output | 1 | Pulse: frame abandoned |
| next_o | output | 1 | Pulse: advance to the next frame |
| stat_done_o | output | 1 | Status of the last frame is final |
| stat_err_o | output | 1 | Frame abandoned by the retry limit |
| stat_late_o | output | 1 | A late collision hit the frame |
| stat_ccount_o | output | 4 | Collisions of the frame, saturating |

## Verification
Every result of this block comes from a register loaded at the clock edge that samples the triggering pulse. So `next_o`, `abort_o`, `retry_req_o` and every status field change exactly one clock after the stimulus. Pulses last that single cycle only. The bench raises each input on a falling edge and clears it on the following falling edge. It reads the outputs at that same falling edge, half a cycle after the edge that updated them. Ignored-input checks read the status and the pulse outputs at that same point.

// File: rtl/txretry_pkg.sv
package txretry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_XMIT    = 2'd1,
    ST_BACKOFF = 2'd2
  } tx_state_e;
endpackage

// File: rtl/txretry_cnt.sv
module txretry_cnt #(
  parameter int MAX_TRIES = 16,
  localparam int ATT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  input  logic single_try_i,
  output logic last_try_o
);
  logic [ATT_W-1:0] att_q, att_d, limit;

  always_comb begin
    att_d = att_q;
    if (clr_i) att_d = ATT_W'(1);
    else if (inc_i && att_q < ATT_W'(MAX_TRIES)) att_d = att_q + ATT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) att_q <= '0;
    else if (clr_i || inc_i) att_q <= att_d;
  end

  assign limit      = single_try_i ? ATT_W'(1) : ATT_W'(MAX_TRIES);
  assign last_try_o = (att_q >= limit);

  // attempts never run past the budget
  assert_att_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= ATT_W'(MAX_TRIES));
endmodule

// File: rtl/txretry_fsm.sv
module txretry_fsm
  import txretry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  input  logic attempt_done_i,
  input  logic coll_i,
  input  logic late_coll_i,
  input  logic backoff_done_i,
  input  logic single_try_i,
  input  logic late_retry_i,
  input  logic last_try_i,
  output logic clr_o,
  output logic inc_o,
  output logic coll_ev_o,
  output logic late_ev_o,
  output logic give_up_o,
  output logic finish_o,
  output logic retry_req_o,
  output logic abort_o,
  output logic next_o
);
  tx_state_e state_q, state_d;
  logic drop, ok;

  always_comb begin
    state_d   = state_q;
    clr_o     = 1'b0;
    inc_o     = 1'b0;
    coll_ev_o = 1'b0;
    late_ev_o = 1'b0;
    give_up_o = 1'b0;
    drop      = 1'b0;
    ok        = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (frame_start_i) begin
          clr_o   = 1'b1;
          state_d = ST_XMIT;
        end
      end
      ST_XMIT: begin
        coll_ev_o = coll_i | late_coll_i;
        late_ev_o = late_coll_i;
        drop      = late_coll_i & ~late_retry_i;
        give_up_o = coll_ev_o & ~drop & last_try_i;
        ok        = attempt_done_i & ~coll_ev_o;
        if (drop || give_up_o || ok) state_d = ST_IDLE;
        else if (coll_ev_o)          state_d = ST_BACKOFF;
      end
      ST_BACKOFF: begin
        if (backoff_done_i) begin
          inc_o   = 1'b1;
          state_d = ST_XMIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign finish_o = drop | give_up_o | ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      retry_req_o <= 1'b0;
      abort_o     <= 1'b0;
      next_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      retry_req_o <= inc_o;
      abort_o     <= drop | give_up_o;
      next_o      <= finish_o;
    end
  end

  assert_retry_after_backoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req_o |-> $past(backoff_done_i));
  assert_abort_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> next_o);
  assert_single_try_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XMIT && coll_i && single_try_i) |=> abort_o);
endmodule

// File: rtl/txretry_stat.sv
module txretry_stat #(
  parameter int CCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              coll_ev_i,
  input  logic              late_ev_i,
  input  logic              give_up_i,
  input  logic              finish_i,
  output logic [CCNT_W-1:0] ccount_o,
  output logic              err_o,
  output logic              late_o,
  output logic              done_o
);
  localparam logic [CCNT_W-1:0] CMAX = '1;
  logic [CCNT_W-1:0] ccount_d;
  logic err_d, late_d, done_d, upd;

  always_comb begin
    ccount_d = ccount_o;
    err_d    = err_o;
    late_d   = late_o;
    done_d   = done_o;
    if (clr_i) begin
      ccount_d = '0;
      err_d    = 1'b0;
      late_d   = 1'b0;
      done_d   = 1'b0;
    end else begin
      if (coll_ev_i && ccount_o != CMAX) ccount_d = ccount_o + 1'b1;
      if (give_up_i) err_d  = 1'b1;
      if (late_ev_i) late_d = 1'b1;
      if (finish_i)  done_d = 1'b1;
    end
  end

  assign upd = clr_i | coll_ev_i | late_ev_i | give_up_i | finish_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccount_o <= '0;
      err_o    <= 1'b0;
      late_o   <= 1'b0;
      done_o   <= 1'b0;
    end else if (upd) begin
      ccount_o <= ccount_d;
      err_o    <= err_d;
      late_o   <= late_d;
      done_o   <= done_d;
    end
  end
endmodule

// File: rtl/txretry_ctrl.sv
module txretry_ctrl #(
  parameter int MAX_TRIES = 16,
  parameter int CCNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              attempt_done_i,
  input  logic              coll_i,
  input  logic              late_coll_i,
  input  logic              backoff_done_i,
  input  logic              single_try_i,
  input  logic              late_retry_i,
  output logic              retry_req_o,
  output logic              abort_o,
  output logic              next_o,
  output logic              stat_done_o,
  output logic              stat_err_o,
  output logic              stat_late_o,
  output logic [CCNT_W-1:0] stat_ccount_o
);
  logic last_try, clr, inc, coll_ev, late_ev, give_up, finish;

  txretry_cnt #(.MAX_TRIES(MAX_TRIES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc),
    .single_try_i(single_try_i), .last_try_o(last_try)
  );

  txretry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(frame_start_i), .attempt_done_i(attempt_done_i),
    .coll_i(coll_i), .late_coll_i(late_coll_i), .backoff_done_i(backoff_done_i),
    .single_try_i(single_try_i), .late_retry_i(late_retry_i), .last_try_i(last_try),
    .clr_o(clr), .inc_o(inc), .coll_ev_o(coll_ev), .late_ev_o(late_ev),
    .give_up_o(give_up), .finish_o(finish),
    .retry_req_o(retry_req_o), .abort_o(abort_o), .next_o(next_o)
  );

  txretry_stat #(.CCNT_W(CCNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .coll_ev_i(coll_ev),
    .late_ev_i(late_ev), .give_up_i(give_up), .finish_i(finish),
    .ccount_o(stat_ccount_o), .err_o(stat_err_o), .late_o(stat_late_o),
    .done_o(stat_done_o)
  );

  // retry error only ever appears together with an abort
  assert_err_with_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err_o) |-> abort_o);
  // status becomes final exactly when the frame is released
  assert_done_with_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_done_o) |-> next_o);
endmodule

// File: tb/txretry_ctrl_test.sv
module txretry_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start, attempt_done, coll, late_coll, backoff_done, single_try, late_retry;
  logic retry_req, abort_p, next_p, st_done, st_err, st_late;
  logic [3:0] st_cnt;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int retries;

  always #5 clk = ~clk;

  txretry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .attempt_done_i(attempt_done),
    .coll_i(coll), .late_coll_i(late_coll), .backoff_done_i(backoff_done),
    .single_try_i(single_try), .late_retry_i(late_retry),
    .retry_req_o(retry_req), .abort_o(abort_p), .next_o(next_p),
    .stat_done_o(st_done), .stat_err_o(st_err), .stat_late_o(st_late), .stat_ccount_o(st_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sel: 1 start, 2 done, 3 coll, 4 late, 5 backoff, 6 done+coll
  task automatic pulse(input int sel);
    @(negedge clk);
    frame_start  = (sel == 1);
    attempt_done = (sel == 2) || (sel == 6);
    coll         = (sel == 3) || (sel == 6);
    late_coll    = (sel == 4);
    backoff_done = (sel == 5);
    @(posedge clk);
    @(negedge clk);
    frame_start = 0; attempt_done = 0; coll = 0; late_coll = 0; backoff_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 retry_req", retry_req, 0); chk("R1 abort", abort_p, 0);
    chk("R1 next", next_p, 0);         chk("R1 done", st_done, 0);
    chk("R1 err", st_err, 0);          chk("R1 late", st_late, 0);
    chk("R1 ccount", st_cnt, 0);
  endtask

  task automatic t_success;
    single_try = 0; late_retry = 0;
    pulse(1);
    chk("R2 cleared done", st_done, 0);
    pulse(2);
    chk("R3 next", next_p, 1); chk("R3 abort", abort_p, 0);
    chk("R3 done", st_done, 1); chk("R3 err", st_err, 0);
    @(negedge clk);
    chk("R3 next one cycle", next_p, 0);
  endtask

  task automatic t_two_retries;
    pulse(1);
    for (int k = 0; k < 2; k++) begin
      pulse(3);
      chk("R4 no abort", abort_p, 0); chk("R4 no next", next_p, 0);
      pulse(5);
      chk("R4 retry_req", retry_req, 1);
    end
    pulse(5);
    chk("R4 backoff_done ignored in attempt", retry_req, 0);
    pulse(2);
    chk("R7 ccount two", st_cnt, 2); chk("R3 next after retries", next_p, 1);
  endtask

  task automatic t_single;
    single_try = 1;
    pulse(1);
    chk("R2 ccount cleared", st_cnt, 0);
    pulse(3);
    chk("R5 abort", abort_p, 1); chk("R5 next", next_p, 1);
    chk("R5 err", st_err, 1);    chk("R7 ccount one", st_cnt, 1);
    single_try = 0;
  endtask

  task automatic t_limit;
    retries = 0;
    pulse(1);
    chk("R2 err cleared", st_err, 0);
    for (int k = 1; k < 16; k++) begin
      pulse(3);
      if (abort_p) chk("R6 early abort", k, 16);
      pulse(5);
      retries += retry_req;
    end
    chk("R6 retry count", retries, 15);
    chk("R7 ccount fifteen", st_cnt, 15);
    pulse(3);
    chk("R6 abort on last", abort_p, 1); chk("R6 err", st_err, 1);
    chk("R7 saturate", st_cnt, 15);
  endtask

  task automatic t_late_drop;
    late_retry = 0;
    pulse(1);
    pulse(4);
    chk("R8 abort", abort_p, 1); chk("R8 late", st_late, 1);
    chk("R8 err", st_err, 0);    chk("R8 ccount", st_cnt, 1);
  endtask

  task automatic t_late_retry;
    late_retry = 1;
    pulse(1);
    chk("R2 late cleared", st_late, 0);
    pulse(4);
    chk("R9 no abort", abort_p, 0); chk("R9 late", st_late, 1);
    pulse(5);
    chk("R9 retry_req", retry_req, 1);
    pulse(1);
    chk("R2 start ignored while busy", st_cnt, 1);
    pulse(2);
    chk("R9 next", next_p, 1); chk("R9 late sticky", st_late, 1);
    late_retry = 0;
  endtask

  task automatic t_idle_ignore;
    pulse(3);
    chk("R10 abort idle", abort_p, 0); chk("R10 next idle", next_p, 0);
    chk("R10 ccount idle", st_cnt, 1);
    pulse(4);
    chk("R10 late idle", st_late, 1); chk("R10 done idle", st_done, 1);
    chk("R10 ccount after late", st_cnt, 1);
  endtask

  task automatic t_same_cycle;
    pulse(1);
    pulse(6);
    chk("R11 no next", next_p, 0); chk("R11 ccount", st_cnt, 1);
    chk("R11 not done", st_done, 0);
    pulse(5);
    pulse(2);
    chk("R11 finished later", next_p, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    frame_start = 0; attempt_done = 0; coll = 0; late_coll = 0; backoff_done = 0;
    single_try = 0; late_retry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_success;
    t_two_retries;
    t_single;
    t_limit;
    t_late_drop;
    t_late_retry;
    t_idle_ignore;
    t_same_cycle;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule